// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of internal registers that do not sit in its own address map. The host sees two words: a command word and a data word. The command word holds an 8-bit internal register index, a direction bit and a busy flag. The host sets busy to launch one transfer. A write copies the data word into the indexed internal register. A read copies the indexed internal register into the data word. Busy then drops, and the host polls it to learn that the transfer is done.

On the internal side the bridge drives a plain request/acknowledge register-bank port. The request stays up, with a steady index, direction and write data, until the bank acknowledges. A host that writes the command word or the data word during a transfer is not allowed to disturb it. Such a write is discarded, and a sticky error flag records it. In the bank attached to this bridge, the media-management access register sits at index 0x6 and the media-management data register sits at index 0x7. The bridge treats these two indices like any other.

Top module: `ind_csr_bridge`

## Requirements
- R1: After reset the command word and the data word read 0, `bk_req` is low and `err_o` is low.
- R2: The command word layout is: bit 31 is busy, bit 30 is the direction (1 = read, 0 = write), bits 7:0 are the internal index, and bits 29:8 always read 0. `h_sel` = 0 selects the command word and `h_sel` = 1 selects the data word.
- R3: A started transfer with direction 0 presents `bk_we` = 1, the stored index on `bk_addr` and the data word on `bk_wdata` until the acknowledge. The internal register then holds the data word.
- R4: A started transfer with direction 1 presents `bk_we` = 0. In the cycle after `bk_ack`, the data word takes the `bk_rdata` value that was present at the acknowledge.
- R5: Busy reads 1 from the cycle after the command write that sets bit 31 until the acknowledge. It reads 0 in the cycle after `bk_ack`.
- R6: A command-word write while busy is 1 is discarded: index, direction and transfer are unchanged. It sets `err_o`, which stays 1 until reset.
- R7: When `DROP_DATA_WR_BUSY` = 1 (the default), a data-word write while busy is 1 is discarded and sets `err_o`.
- R8: A command-word write with bit 31 = 0 while idle stores the index and the direction and starts no transfer, so `bk_req` stays low.
- R9: While `bk_req` is 1 and no acknowledge has arrived, `bk_addr`, `bk_we` and `bk_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_sel | input | 1 | Host word select: 0 = command word, 1 = data word |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Selected word, read combinationally |
| err_o | output | 1 | Sticky flag for host writes discarded during a transfer |
| bk_req | output | 1 | Internal bank request |
| bk_we | output | 1 | Internal bank write enable |
| bk_addr | output | ADDR_W | Internal register index |
| bk_wdata | output | DATA_W | Internal write data |
| bk_rdata | input | DATA_W | Internal read data |
| bk_ack | input | 1 | Internal bank acknowledge |

## Verification
The faults that matter most are internal state that is wrong but hidden: a stuck busy bit, a latched index that changes during a transfer, or a read capture taken on the wrong cycle.

- **Busy flag.** A stuck or early-clearing busy bit shows up in the host's busy poll as a busy duration other than the bank latency plus two cycles.
- **Index or data during a transfer.** A changed index or data word mid-transfer shows up as a wrong value in the bench's bank model once the transfer ends.
- **Discarded writes.** A discarded write that leaked through shows up in the command word or the data word right after the transfer. It also shows in `err_o` one cycle after the offending write.

// File: rtl/ind_csr_pkg.sv
package ind_csr_pkg;

   typedef enum logic {
      SEL_CMD  = 1'b0,
      SEL_DATA = 1'b1
   } host_sel_e;

   // Bit positions of the flag fields inside a command word of width w
   function automatic int busy_pos(input int w);
      return w - 1;
   endfunction

   function automatic int dir_pos(input int w);
      return w - 2;
   endfunction

endpackage

// File: rtl/ind_csr_cmd.sv
module ind_csr_cmd #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter bit DROP_DATA_WR_BUSY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bk_ack,
   output logic              busy,
   output logic              dir_rd,
   output logic [ADDR_W-1:0] idx,
   output logic              err
);
   import ind_csr_pkg::*;

   localparam int BUSY_B = busy_pos(DATA_W);
   localparam int DIR_B  = dir_pos(DATA_W);

   logic drop_seen;

   always_comb begin
      drop_seen = busy & (cmd_wr | (data_wr & DROP_DATA_WR_BUSY));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         dir_rd <= 1'b0;
         idx    <= '0;
         err    <= 1'b0;
      end else begin
         if (cmd_wr && !busy) begin
            busy   <= wdata[BUSY_B];
            dir_rd <= wdata[DIR_B];
            idx    <= wdata[ADDR_W-1:0];
         end else if (busy && bk_ack) begin
            busy <= 1'b0;
         end
         if (drop_seen) err <= 1'b1;
      end
   end

   p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bk_ack |=> busy);
   p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bk_ack |=> !busy);
   p_cmd_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_wr |=> err && idx == $past(idx) && dir_rd == $past(dir_rd));
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && cmd_wr && !wdata[BUSY_B] |=> !busy);

endmodule

// File: rtl/ind_csr_data.sv
module ind_csr_data #(
   parameter int DATA_W = 32,
   parameter bit DROP_DATA_WR_BUSY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic              busy,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] bk_rdata,
   output logic [DATA_W-1:0] data_q
);
   logic host_ld;

   generate
      if (DROP_DATA_WR_BUSY) begin : g_guarded
         always_comb host_ld = data_wr & ~busy;
      end else begin : g_open
         always_comb host_ld = data_wr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       data_q <= '0;
      else if (rd_done) data_q <= bk_rdata;
      else if (host_ld) data_q <= wdata;
   end

   p_read_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> data_q == $past(bk_rdata));

   generate
      if (DROP_DATA_WR_BUSY) begin : g_chk
         p_data_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            busy && data_wr && !rd_done |=> $stable(data_q));
      end
   endgenerate

endmodule

// File: rtl/ind_csr_bridge.sv
module ind_csr_bridge #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter bit DROP_DATA_WR_BUSY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic              h_sel,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   output logic              err_o,
   output logic              bk_req,
   output logic              bk_we,
   output logic [ADDR_W-1:0] bk_addr,
   output logic [DATA_W-1:0] bk_wdata,
   input  logic [DATA_W-1:0] bk_rdata,
   input  logic              bk_ack
);
   import ind_csr_pkg::*;

   localparam int BUSY_B = busy_pos(DATA_W);
   localparam int DIR_B  = dir_pos(DATA_W);

   initial begin
      if (ADDR_W < 1 || DATA_W < ADDR_W + 3)
         $fatal(1, "ind_csr_bridge: DATA_W must leave room for index, flags and one reserved bit");
   end

   logic              cmd_wr, data_wr, busy, dir_rd, rd_done;
   logic [ADDR_W-1:0] idx;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] cmd_word;

   always_comb begin
      cmd_wr  = h_wr & (h_sel == SEL_CMD);
      data_wr = h_wr & (h_sel == SEL_DATA);
      rd_done = busy & bk_ack & dir_rd;
   end

   ind_csr_cmd #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DROP_DATA_WR_BUSY(DROP_DATA_WR_BUSY)
   ) i_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
      .wdata(h_wdata), .bk_ack(bk_ack), .busy(busy), .dir_rd(dir_rd),
      .idx(idx), .err(err_o)
   );

   ind_csr_data #(
      .DATA_W(DATA_W), .DROP_DATA_WR_BUSY(DROP_DATA_WR_BUSY)
   ) i_data (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .busy(busy),
      .rd_done(rd_done), .wdata(h_wdata), .bk_rdata(bk_rdata), .data_q(data_q)
   );

   always_comb begin
      cmd_word                = '0;
      cmd_word[BUSY_B]        = busy;
      cmd_word[DIR_B]         = dir_rd;
      cmd_word[ADDR_W-1:0]    = idx;
      h_rdata  = (h_sel == SEL_DATA) ? data_q : cmd_word;
      bk_req   = busy;
      bk_we    = busy & ~dir_rd;
      bk_addr  = idx;
      bk_wdata = data_q;
   end

   p_req_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bk_req && !bk_ack |=> $stable(bk_addr) && $stable(bk_we) && $stable(bk_wdata));
   p_write_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bk_req |-> bk_we == !h_rdata[DIR_B] || h_sel == SEL_DATA);
   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      h_sel == SEL_CMD |-> h_rdata[DIR_B-1:ADDR_W] == '0);

endmodule

// File: tb/test_ind_csr_bridge.sv
module test_ind_csr_bridge;
   localparam int CLK_P = 10;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_wr = 1'b0, h_sel = 1'b0;
   logic [DW-1:0] h_wdata = '0, h_rdata;
   logic          err_o, bk_req, bk_we, bk_ack = 1'b0;
   logic [AW-1:0] bk_addr;
   logic [DW-1:0] bk_wdata, bk_rdata;

   int errors = 0, checks = 0, lat = 0, cnt = 0;
   logic [DW-1:0] mem [256];

   always #(CLK_P/2) clk = ~clk;

   ind_csr_bridge i_ind_csr_bridge (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_sel(h_sel), .h_wdata(h_wdata),
      .h_rdata(h_rdata), .err_o(err_o), .bk_req(bk_req), .bk_we(bk_we),
      .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_rdata(bk_rdata), .bk_ack(bk_ack)
   );

   // Bench model of the internal register bank, acknowledges after lat idle cycles
   assign bk_rdata = mem[bk_addr];
   always @(posedge clk) begin
      if (bk_req && !bk_ack) begin
         if (cnt == lat) begin
            bk_ack <= 1'b1;
            cnt <= 0;
            if (bk_we) mem[bk_addr] <= bk_wdata;
         end else cnt <= cnt + 1;
      end else bk_ack <= 1'b0;
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic sel, input logic [DW-1:0] d);
      @(negedge clk);
      h_wr = 1'b1; h_sel = sel; h_wdata = d;
      @(negedge clk);
      h_wr = 1'b0; h_sel = 1'b0;
   endtask

   task automatic hrd(input logic sel, output logic [DW-1:0] d);
      h_sel = sel; #1; d = h_rdata;
   endtask

   // Waits for busy low; returns number of cycles busy was seen high
   task automatic poll(output int n);
      logic [DW-1:0] w;
      n = 0;
      hrd(1'b0, w);
      while (w[31] && n < 200) begin
         @(negedge clk); n++; hrd(1'b0, w);
      end
   endtask

   // Vectors: {dir, index, value}; for reads value is the expected bank content
   localparam logic [40:0] VEC [8] = '{
      {1'b0, 8'h06, 32'hA5A5_0001}, {1'b0, 8'h07, 32'h1234_5678},
      {1'b0, 8'h00, 32'hFFFF_FFFF}, {1'b0, 8'hFF, 32'h8000_0001},
      {1'b1, 8'h06, 32'hA5A5_0001}, {1'b1, 8'h07, 32'h1234_5678},
      {1'b1, 8'hFF, 32'h8000_0001}, {1'b1, 8'h00, 32'hFFFF_FFFF}};

   initial begin
      #(CLK_P * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] w;
      int n;
      for (int i = 0; i < 256; i++) mem[i] = 32'(i) ^ 32'h5A00_0000;
      repeat (3) @(negedge clk);
      // R1 reset state
      hrd(1'b0, w); chk("R1 cmd", w, 0);
      hrd(1'b1, w); chk("R1 data", w, 0);
      chk("R1 req/err", {30'b0, bk_req, err_o}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < 8; v++) begin
         lat = v % 4;
         if (!VEC[v][40]) hwr(1'b1, VEC[v][31:0]);
         hwr(1'b0, {1'b1, VEC[v][40], 22'h3FFFFF, VEC[v][39:32]});
         chk(VEC[v][40] ? "R4 dir" : "R3 dir", {31'b0, bk_we}, {31'b0, !VEC[v][40]});
         chk("R9 index", {24'b0, bk_addr}, {24'b0, VEC[v][39:32]});
         poll(n);
         chk("R5 busy cycles", n, lat + 2);
         if (VEC[v][40]) begin
            hrd(1'b1, w); chk("R4 read data", w, VEC[v][31:0]);
         end else chk("R3 bank content", mem[VEC[v][39:32]], VEC[v][31:0]);
         hrd(1'b0, w);
         chk("R2 cmd layout", w, {1'b0, VEC[v][40], 22'b0, VEC[v][39:32]});
      end
      chk("R6 no err yet", {31'b0, err_o}, 0);

      // R8: no-start write stores fields, reserved bits read zero
      hwr(1'b0, {1'b0, 1'b1, 22'h3FFFFF, 8'h33});
      repeat (3) @(negedge clk);
      chk("R8 no req", {31'b0, bk_req}, 0);
      hrd(1'b0, w); chk("R8 fields", w, {2'b01, 22'b0, 8'h33});

      // R7: data write during a write transfer is discarded
      lat = 5;
      hwr(1'b1, 32'hCAFE_0042);
      hwr(1'b0, {2'b10, 22'b0, 8'h42});
      hwr(1'b1, 32'hDEAD_BEEF);
      chk("R7 err set", {31'b0, err_o}, 1);
      poll(n);
      chk("R7 bank kept", mem[8'h42], 32'hCAFE_0042);
      hrd(1'b1, w); chk("R7 data kept", w, 32'hCAFE_0042);

      // R6: command write during a read transfer is discarded
      hwr(1'b0, {2'b11, 22'b0, 8'h10});
      hwr(1'b0, {2'b10, 22'b0, 8'h20});
      chk("R9 index steady", {24'b0, bk_addr}, 32'h10);
      poll(n);
      hrd(1'b0, w); chk("R6 cmd kept", w, {2'b01, 22'b0, 8'h10});
      hrd(1'b1, w); chk("R6 read ok", w, mem[8'h10]);
      repeat (4) @(negedge clk);
      chk("R6 err sticky", {31'b0, err_o}, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule